// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block behaves as the slave side of a three-wire serial EEPROM. It runs on the system clock. The chip-select, serial-clock and data-in pins are brought in through a synchroniser, and rising serial-clock edges are found from the synchronised copy. After a start bit, the block collects a two-bit opcode, an address and, for the two data-carrying program commands, a data word. It then reads from or programs an internal byte array. An organisation input chooses whether that array is seen as bytes or as 16-bit words.

Programming is protected in two ways. A write-enable latch is off after reset and is set and cleared by dedicated commands. A program-enable input must also be high. A programming cycle is represented by a down-counter. Once chip select has gone low and come back high, the data-out pin reports busy or ready. Reads start with a dummy zero and then keep streaming from successive addresses for as long as chip select stays high. Data out has its own output enable, which represents the high-impedance state.

Top module: `uw_eeprom`

## Requirements
- R1: Before a start bit (chip select high and data-in high at a rising serial-clock edge), rising edges that sample data-in low cause no operation, and data out stays disabled.
- R2: The two opcode bits that follow the start bit select the command: 10 read, 01 write, 11 erase. With 00, the two most significant address bits select the command: 10 erase-all, 01 write-all, 11 write-enable, 00 write-disable.
- R3: With the organisation input low, the address is 11 bits and the data is 8 bits. With it high, the address is 10 bits and the data is 16 bits. Both go MSB first. Word w maps to byte 2w as its high half and to byte 2w+1 as its low half. Address bits above the array depth are ignored.
- R4: A read enables data out and drives a dummy 0 after the last address bit. Each later rising serial-clock edge presents the next data bit, MSB first.
- R5: While chip select stays high, a read continues with the next address without another dummy bit. After the last address of the array it wraps to address 0.
- R6: After reset, the write-enable latch is off, every byte of the array reads 0xFF, and data out is disabled.
- R7: The write-enable command permits programming until a write-disable command is received. Reads work whether the latch is on or off.
- R8: Erase sets one location to all ones and erase-all sets the whole array to all ones. Write stores one location. Write-all stores the data word into every location.
- R9: A low program-enable input blocks every programming command, and the array is left unchanged.
- R10: If chip select falls before all the bits of an instruction have arrived, the instruction is dropped and the array is unchanged.
- R11: After a programming command, data out stays disabled while chip select remains high. Once chip select has gone low and then high again, data out shows 0 for BUSY_CYCLES clocks and then shows 1.
- R12: A start bit sent while the programming cycle is still busy is ignored. A start bit sent once the cycle is ready clears the status and begins a new instruction.
- R13: Data out is disabled whenever chip select is low. A blocked programming command produces no status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Serial chip select, active high |
| sck_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organisation: 1 for 16-bit words, 0 for bytes |
| pe_i | input | 1 | Program enable; low blocks programming |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Data-out enable; low means high impedance |

## Verification
A shift counter that is off by one shows up on the first read: the dummy zero appears one serial clock early or late, or the address is misframed. Either way, data out differs within the same serial-clock cycle. A write-enable latch or address decode held in the wrong state stays hidden until the next read of the affected location, so every programming command is followed by a read-back. A busy counter or status flag in the wrong state shows at the first chip-select rise after the command, through the busy and ready levels or through an enable that should not be there.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_HOLD,
    ST_PROG,
    ST_STAT
  } uw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EXT_WDIS = 2'b00;
  localparam logic [1:0] EXT_WALL = 2'b01;
  localparam logic [1:0] EXT_EALL = 2'b10;
  localparam logic [1:0] EXT_WEN  = 2'b11;

  localparam int SHIFT_W = 16;
endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= g_stage[s-1].q;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/uw_mem.sv
module uw_mem #(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              org,
  input  logic [MEM_AW-1:0] rd_idx,
  output logic [15:0]       rd_word,
  input  logic              we,
  input  logic              we_all,
  input  logic [MEM_AW-1:0] wr_idx,
  input  logic [15:0]       wr_data
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int FLAT_W = DEPTH * 8;

  logic [FLAT_W-1:0]  flat;
  logic [MEM_AW-1:0]  hi_idx;
  logic [MEM_AW-1:0]  lo_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [MEM_AW-1:0] BYTE_IDX = MEM_AW'(g);
    logic       hit;
    logic [7:0] val;
    logic [7:0] q;

    always_comb begin
      if (org) begin
        hit = we_all || (wr_idx[MEM_AW-2:0] == BYTE_IDX[MEM_AW-1:1]);
        val = BYTE_IDX[0] ? wr_data[7:0] : wr_data[15:8];
      end else begin
        hit = we_all || (wr_idx == BYTE_IDX);
        val = wr_data[7:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= 8'hFF;
      else if (we && hit)  q <= val;
    end

    assign flat[8*g +: 8] = q;
  end

  assign hi_idx = {rd_idx[MEM_AW-2:0], 1'b0};
  assign lo_idx = {rd_idx[MEM_AW-2:0], 1'b1};

  always_comb begin
    if (org) rd_word = {flat[{hi_idx, 3'b000} +: 8], flat[{lo_idx, 3'b000} +: 8]};
    else     rd_word = {8'h00, flat[{rd_idx, 3'b000} +: 8]};
  end
endmodule

// File: rtl/uw_ctrl.sv
module uw_ctrl
  import uw_pkg::*;
#(
  parameter int MEM_AW      = 6,
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sck_rise,
  input  logic              di,
  input  logic              org,
  input  logic              pe,
  input  logic [15:0]       rd_word,
  output logic [MEM_AW-1:0] rd_idx,
  output logic              mem_we,
  output logic              mem_all,
  output logic [MEM_AW-1:0] wr_idx,
  output logic [15:0]       wr_data,
  output logic              do_o,
  output logic              do_oe,
  output logic              ewen_o,
  output logic              busy_nz_o,
  output uw_state_e         state_o
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  uw_state_e         state_q, state_d;
  logic [4:0]        cnt_q, cnt_d, cnt_inc;
  logic [SHIFT_W-2:0] sr_q, sr_d;
  logic [SHIFT_W-1:0] sr_sh;
  logic [1:0]        op_q, op_d;
  logic [MEM_AW-1:0] addr_q, addr_d;
  logic              ewen_q, ewen_d;
  logic              do_q, do_d;
  logic [3:0]        bit_q, bit_d;
  logic [BW-1:0]     busy_q, busy_d;

  logic [4:0]        hdr_len, full_len;
  logic [3:0]        last_bit;
  logic [1:0]        hdr_op, hdr_ext;
  logic [MEM_AW-1:0] hdr_idx;
  logic              ready;
  logic              prog_req, prog_all;
  logic [15:0]       prog_data;
  logic [MEM_AW-1:0] prog_idx;

  assign sr_sh    = {sr_q, di};
  assign cnt_inc  = cnt_q + 5'd1;
  assign hdr_len  = org ? 5'd12 : 5'd13;
  assign full_len = org ? 5'd28 : 5'd21;
  assign last_bit = org ? 4'd15 : 4'd7;
  assign hdr_op   = org ? sr_sh[11:10] : sr_sh[12:11];
  assign hdr_ext  = org ? sr_sh[9:8]   : sr_sh[10:9];
  assign hdr_idx  = org ? {1'b0, sr_sh[MEM_AW-2:0]} : sr_sh[MEM_AW-1:0];
  assign ready    = (busy_q == '0);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sr_d      = sr_q;
    op_d      = op_q;
    addr_d    = addr_q;
    ewen_d    = ewen_q;
    do_d      = do_q;
    bit_d     = bit_q;
    busy_d    = ready ? busy_q : busy_q - BW'(1);
    prog_req  = 1'b0;
    prog_all  = 1'b0;
    prog_data = 16'hFFFF;
    prog_idx  = addr_q;
    mem_we    = 1'b0;

    if (!cs) begin
      if (state_q == ST_PROG || state_q == ST_STAT) state_d = ST_STAT;
      else                                          state_d = ST_IDLE;
    end else if (sck_rise) begin
      case (state_q)
        ST_IDLE, ST_STAT: begin
          if (di && (state_q == ST_IDLE || ready)) begin
            state_d = ST_CMD;
            cnt_d   = '0;
            sr_d    = '0;
          end
        end
        ST_CMD: begin
          sr_d  = sr_sh[SHIFT_W-2:0];
          cnt_d = cnt_inc;
          if (cnt_inc == hdr_len) begin
            op_d   = hdr_op;
            addr_d = hdr_idx;
            case (hdr_op)
              OP_READ: begin
                state_d = ST_READ;
                do_d    = 1'b0;
                bit_d   = last_bit;
              end
              OP_ERASE: begin
                prog_req = 1'b1;
                prog_idx = hdr_idx;
              end
              OP_WRITE: ;
              default: begin
                case (hdr_ext)
                  EXT_EALL: begin
                    prog_req = 1'b1;
                    prog_all = 1'b1;
                  end
                  EXT_WEN: begin
                    ewen_d  = 1'b1;
                    state_d = ST_HOLD;
                  end
                  EXT_WDIS: begin
                    ewen_d  = 1'b0;
                    state_d = ST_HOLD;
                  end
                  default: ;
                endcase
              end
            endcase
          end else if (cnt_inc == full_len) begin
            prog_req  = 1'b1;
            prog_all  = (op_q == OP_EXT);
            prog_data = org ? sr_sh : {8'h00, sr_sh[7:0]};
          end
        end
        ST_READ: begin
          do_d = rd_word[bit_q];
          if (bit_q == 4'd0) begin
            bit_d  = last_bit;
            addr_d = addr_q + MEM_AW'(1);
          end else begin
            bit_d = bit_q - 4'd1;
          end
        end
        default: ;
      endcase
    end

    if (prog_req) begin
      if (ewen_q && pe) begin
        mem_we  = 1'b1;
        busy_d  = BW'(BUSY_CYCLES);
        state_d = ST_PROG;
      end else begin
        state_d = ST_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      op_q    <= OP_EXT;
      addr_q  <= '0;
      ewen_q  <= 1'b0;
      do_q    <= 1'b0;
      bit_q   <= '0;
      busy_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sr_q    <= sr_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      ewen_q  <= ewen_d;
      do_q    <= do_d;
      bit_q   <= bit_d;
      busy_q  <= busy_d;
    end
  end

  assign rd_idx    = addr_q;
  assign mem_all   = prog_all;
  assign wr_idx    = prog_idx;
  assign wr_data   = prog_data;
  assign do_o      = (state_q == ST_STAT) ? ready : do_q;
  assign do_oe     = cs && (state_q == ST_READ || state_q == ST_STAT);
  assign ewen_o    = ewen_q;
  assign busy_nz_o = !ready;
  assign state_o   = state_q;
endmodule

// File: rtl/uw_eeprom.sv
module uw_eeprom
  import uw_pkg::*;
#(
  parameter int MEM_AW      = 6,
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic di_i,
  input  logic org_i,
  input  logic pe_i,
  output logic do_o,
  output logic do_oe_o
);
  logic [1:0]        rst_pipe;
  logic              srst_n;
  logic [2:0]        sync_q;
  logic              cs_s, sck_s, di_s, sck_d, sck_rise;
  logic [15:0]       rd_word;
  logic [MEM_AW-1:0] rd_idx, wr_idx;
  logic              mem_we, mem_all;
  logic [15:0]       wr_data;
  logic              ewen, busy_nz;
  uw_state_e         state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  uw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d_i   ({cs_i, sck_i, di_i}),
    .q_o   (sync_q)
  );
  assign cs_s  = sync_q[2];
  assign sck_s = sync_q[1];
  assign di_s  = sync_q[0];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sck_d <= 1'b0;
    else         sck_d <= sck_s;
  end
  assign sck_rise = sck_s && !sck_d;

  uw_ctrl #(.MEM_AW(MEM_AW), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .cs        (cs_s),
    .sck_rise  (sck_rise),
    .di        (di_s),
    .org       (org_i),
    .pe        (pe_i),
    .rd_word   (rd_word),
    .rd_idx    (rd_idx),
    .mem_we    (mem_we),
    .mem_all   (mem_all),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .do_o      (do_o),
    .do_oe     (do_oe_o),
    .ewen_o    (ewen),
    .busy_nz_o (busy_nz),
    .state_o   (state)
  );

  uw_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk     (clk),
    .rst_n   (srst_n),
    .org     (org_i),
    .rd_idx  (rd_idx),
    .rd_word (rd_word),
    .we      (mem_we),
    .we_all  (mem_all),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
  );
endmodule

// File: rtl/uw_eeprom_chk.sv
module uw_eeprom_chk
  import uw_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs_s,
  input logic      do_oe,
  input logic      mem_we,
  input logic      ewen,
  input logic      pe,
  input logic      busy_nz,
  input uw_state_e state
);
  // R13: data out released while chip select is low
  p_hiz_cs_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |-> !do_oe);

  // R9 / R7: array written only with latch on and program enable high
  p_write_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ewen && pe));

  // R11: every array write starts a busy cycle
  p_prog_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (busy_nz && state == ST_PROG));

  // R12: no new instruction accepted while busy
  p_busy_ignores_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_nz && state == ST_STAT) |=> state != ST_CMD);
endmodule

bind uw_eeprom uw_eeprom_chk u_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .cs_s    (cs_s),
  .do_oe   (do_oe_o),
  .mem_we  (mem_we),
  .ewen    (ewen),
  .pe      (pe_i),
  .busy_nz (busy_nz),
  .state   (state)
);

// File: tb/tb_uw_eeprom.sv
module tb_uw_eeprom;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 6;
  localparam int BUSY       = 64;
  localparam int NBYTES     = 1 << MEM_AW;

  logic clk, rst_n, cs, sck, di, org, pe;
  logic do_o, do_oe;

  uw_eeprom #(.MEM_AW(MEM_AW), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di),
    .org_i(org), .pe_i(pe), .do_o(do_o), .do_oe_o(do_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  logic  chk_en = 1'b0;
  logic  exp_oe = 1'b0;
  logic  exp_do = 1'b0;
  string req = "R6";
  logic [7:0] mem_m [NBYTES];
  bit    ewen_m = 0;

  // reference comparison on every clock while an expectation is armed
  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (do_oe !== exp_oe || (exp_oe && do_o !== exp_do)) begin
        errors++;
        $display("FAIL %s: got oe=%b do=%b expected oe=%b do=%b at %0t",
                 req, do_oe, do_o, exp_oe, exp_do, $time);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_now(input logic eoe, input logic edo, input int n);
    exp_oe = eoe; exp_do = edo; chk_en = 1'b1;
    step(n);
    chk_en = 1'b0;
  endtask

  task automatic sbit(input logic b, input logic eoe, input logic edo);
    di = b; sck = 1'b1;
    step(5);
    expect_now(eoe, edo, 2);
    sck = 1'b0;
    step(5);
    expect_now(eoe, edo, 2);
  endtask

  task automatic cs_set(input logic v, input logic eoe, input logic edo);
    cs = v;
    step(5);
    expect_now(eoe, edo, 2);
  endtask

  function automatic logic [15:0] model_word(input int a);
    int w;
    if (org) begin
      w = a % (NBYTES/2);
      return {mem_m[2*w], mem_m[2*w+1]};
    end
    return {8'h00, mem_m[a % NBYTES]};
  endfunction

  function automatic int ext_addr(input logic [1:0] ext);
    return org ? (int'(ext) << 8) : (int'(ext) << 9);
  endfunction

  task automatic send_hdr(input logic [1:0] op, input int addr, input bit is_read);
    int aw;
    aw = org ? 10 : 11;
    sbit(1'b1, 1'b0, 1'b0);
    sbit(op[1], 1'b0, 1'b0);
    sbit(op[0], 1'b0, 1'b0);
    for (int i = aw - 1; i >= 0; i--)
      sbit(addr[i], (is_read && i == 0), 1'b0);
  endtask

  task automatic rd(input string r, input int addr, input int n);
    int a, dw;
    logic [15:0] w;
    req = r;
    a  = addr;
    dw = org ? 16 : 8;
    send_hdr(2'b10, addr, 1'b1);
    for (int k = 0; k < n; k++) begin
      w = model_word(a);
      for (int i = dw - 1; i >= 0; i--) sbit(1'b0, 1'b1, w[i]);
      a = (a + 1) % (org ? NBYTES/2 : NBYTES);
    end
    cs_set(1'b0, 1'b0, 1'b0);
    cs_set(1'b1, 1'b0, 1'b0);
  endtask

  // kind: 0 write, 1 erase, 2 erase-all, 3 write-all
  task automatic prog(input string r, input int kind, input int addr,
                      input logic [15:0] data, input bit poke);
    int dw, w;
    bit ok;
    req = r;
    dw  = org ? 16 : 8;
    case (kind)
      0: send_hdr(2'b01, addr, 1'b0);
      1: send_hdr(2'b11, addr, 1'b0);
      2: send_hdr(2'b00, ext_addr(2'b10), 1'b0);
      default: send_hdr(2'b00, ext_addr(2'b01), 1'b0);
    endcase
    if (kind == 0 || kind == 3)
      for (int i = dw - 1; i >= 0; i--) sbit(data[i], 1'b0, 1'b0);
    ok = ewen_m && pe;
    if (ok) begin
      for (int b = 0; b < NBYTES; b++) begin
        w = org ? (b / 2) : b;
        if (kind >= 2 || w == (org ? addr % (NBYTES/2) : addr % NBYTES)) begin
          if (kind == 1 || kind == 2) mem_m[b] = 8'hFF;
          else if (org)               mem_m[b] = (b % 2 == 0) ? data[15:8] : data[7:0];
          else                        mem_m[b] = data[7:0];
        end
      end
    end
    cs_set(1'b0, 1'b0, 1'b0);
    if (ok) begin
      req = "R11";
      cs_set(1'b1, 1'b1, 1'b0);
      if (poke) begin
        req = "R12";
        sbit(1'b1, 1'b1, 1'b0);
      end
      step(BUSY + 20);
      req = "R11";
      expect_now(1'b1, 1'b1, 3);
    end else begin
      req = "R13";
      cs_set(1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic ext_cmd(input string r, input logic [1:0] ext);
    req = r;
    send_hdr(2'b00, ext_addr(ext), 1'b0);
    if (ext == 2'b11) ewen_m = 1;
    if (ext == 2'b00) ewen_m = 0;
    cs_set(1'b0, 1'b0, 1'b0);
    cs_set(1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; cs = 1'b0; sck = 1'b0; di = 1'b0; org = 1'b0; pe = 1'b1;
    for (int b = 0; b < NBYTES; b++) mem_m[b] = 8'hFF;
    step(2);
    req = "R6";
    expect_now(1'b0, 1'b0, 3);
    rst_n = 1'b1;
    step(4);
    expect_now(1'b0, 1'b0, 2);

    // R1: clock edges with DI low before any start bit do nothing
    req = "R1";
    cs_set(1'b1, 1'b0, 1'b0);
    sbit(1'b0, 1'b0, 1'b0);
    sbit(1'b0, 1'b0, 1'b0);
    sbit(1'b0, 1'b0, 1'b0);
    rd("R4", 0, 1);

    // R7: write refused while the latch is off after reset (R6)
    prog("R7", 0, 3, 16'h005A, 0);
    rd("R6", 3, 1);

    ext_cmd("R2", 2'b11);
    prog("R8", 3, 0, 16'h003C, 0);          // write-all
    prog("R8", 0, 0, 16'h0011, 0);
    prog("R8", 0, 3, 16'h005A, 0);
    rd("R5", 63, 2);                         // wrap to address 0
    rd("R5", 2, 2);

    prog("R8", 1, 3, 16'h0000, 0);          // erase one location
    rd("R8", 3, 1);

    // R10: chip select drops in the data phase
    req = "R10";
    send_hdr(2'b01, 5, 1'b0);
    sbit(1'b1, 1'b0, 1'b0);
    sbit(1'b0, 1'b0, 1'b0);
    sbit(1'b1, 1'b0, 1'b0);
    cs_set(1'b0, 1'b0, 1'b0);
    cs_set(1'b1, 1'b0, 1'b0);
    rd("R10", 5, 1);

    // R3: high address bits beyond the array are ignored
    prog("R3", 0, 11'h046, 16'h00A7, 0);
    rd("R3", 6, 1);

    // R3: 16-bit organisation and byte placement
    org = 1'b1;
    step(2);
    prog("R3", 0, 5, 16'hBEEF, 0);
    rd("R3", 5, 1);
    rd("R5", 31, 2);
    org = 1'b0;
    step(2);
    rd("R3", 10, 2);

    // R9: program enable low blocks programming
    pe = 1'b0;
    prog("R9", 0, 7, 16'h0000, 0);
    pe = 1'b1;
    rd("R9", 7, 1);

    // R12: start bit during busy is ignored
    prog("R12", 0, 8, 16'h0081, 1);
    rd("R12", 8, 1);

    // R7: write-disable blocks, reads still work
    ext_cmd("R7", 2'b00);
    prog("R7", 0, 9, 16'h0000, 0);
    rd("R7", 9, 1);

    ext_cmd("R2", 2'b11);
    prog("R8", 2, 0, 16'h0000, 0);          // erase-all
    rd("R8", 0, 3);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule